// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Cross-Domain Register Writes

This block produces pulse-width modulated outputs for several channels. Software programs each channel through a simple memory-mapped bus that runs on its own clock. The counters and the outputs run on a separate PWM clock. Each channel has four registers: a run/output control word, a clock prescaler, a period limit and a duty threshold.

Each register write is handed into the PWM clock domain by a toggle handshake. A per-register busy flag in a byte-wide status location stays set until the PWM domain has taken the value and acknowledged it. Software polls this flag before it writes the same register again. New timing values are applied only at the end of a running period, so an output pulse is never cut short.

The address map has room for four channel slots. Only the first `NCH` slots are built, and the empty slots read as zero.

Top module: `pwmx_top`

## Requirements
- R1: Slot c has its registers at byte offsets c*0x10 + {0x0 control, 0x4 prescale, 0x8 period, 0xC duty}. A read returns the last accepted value, zero-extended. The stored field widths are control 3 bits, prescale 10 bits, period 12 bits and duty 12 bits, and higher write bits are dropped.
- R2: The status byte of slot c is at 0x40 + c. Bit 0 flags control busy, bit 1 prescale, bit 2 period and bit 3 duty. A flag reads as set from the bus cycle after an accepted write until the value has crossed to the PWM domain and the acknowledge has come back.
- R3: A write to a register whose busy flag is set is discarded. The register keeps its earlier value.
- R4: While the counter runs, the output repeats every (prescale+1)*(period+1) PWM clocks.
- R5: Within each period, the output is high for (prescale+1)*min(duty, period+1) PWM clocks, counted from the start of the period.
- R6: A duty value above the period value gives a constant high output. A duty value of 0 gives a constant low output.
- R7: Control bit 0 runs the counter and control bit 2 enables the output. The output is high only when both bits are set. Writing 5 starts a channel. Writing 0, 1 or 4 holds the output low.
- R8: Prescale, period and duty changes made while the channel runs take effect only at the next period boundary. The high pulse in progress keeps its old length.
- R9: Addresses in unbuilt channel slots, and status bytes of unbuilt slots, read as zero. Writes to them change nothing.
- R10: After reset, every register and status byte reads zero and every output is low.
- R11: Channels are independent. Programming one channel does not change the waveform of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| pclk | input | 1 | PWM counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_we | input | 1 | Write strobe, sampled on bclk |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NCH | One PWM output per built channel |

## Verification
The bench writes a register twice in quick succession. A design that accepted writes while busy would read back the second value instead of the first. It also reads the status byte one cycle after a write, to catch a flag that is set late or not at all. It changes the duty value in the middle of a long high pulse and measures both that pulse and the next one. A design that loaded new values at once would shorten the running pulse. The bench also covers duty above the period, duty of zero, a one-clock prescale and the control words that hold the output low. Each of these shows up as a wrong high count or wrong edge count over a window of whole periods.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
  localparam int SLOTS      = 4;
  localparam int REGS       = 4;
  localparam int SLOT_BYTES = 16;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 32;
  localparam int CTRL_W     = 3;
  localparam int PRE_W      = 10;
  localparam int PER_W      = 12;
  localparam int RUN_BIT    = 0;
  localparam int OEN_BIT    = 2;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_PRE  = 2'd1,
    REG_PER  = 2'd2,
    REG_DUTY = 2'd3
  } reg_e;
endpackage

// File: rtl/pwmx_sync2.sv
module pwmx_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/pwmx_xfer.sv
module pwmx_xfer #(
  parameter int W = 8
) (
  input  logic         bclk,
  input  logic         brst_n,
  input  logic         pclk,
  input  logic         prst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] hold,
  output logic         busy,
  output logic [W-1:0] pval
);
  logic req, req_p, req_d, ack_b, accept;

  // bus side: hold the value and toggle the request
  assign accept = wr_en && !busy;

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      hold <= '0;
      req  <= 1'b0;
    end else if (accept) begin
      hold <= wdata;
      req  <= ~req;
    end
  end

  pwmx_sync2 u_req_sync (.clk(pclk), .rst_n(prst_n), .d(req),   .q(req_p));
  pwmx_sync2 u_ack_sync (.clk(bclk), .rst_n(brst_n), .d(req_d), .q(ack_b));

  assign busy = req ^ ack_b;

  // pwm side: capture on a request edge, acknowledge with req_d
  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      req_d <= 1'b0;
      pval  <= '0;
    end else begin
      req_d <= req_p;
      if (req_p != req_d) pval <= hold;
    end
  end

  // R3
  ign_busy_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (wr_en && busy) |=> $stable(hold));

  // R2
  busy_set_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (wr_en && !busy) |=> busy);
endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
  import pwmx_pkg::*;
(
  input  logic             bclk,
  input  logic             brst_n,
  input  logic             pclk,
  input  logic             prst_n,
  input  logic [REGS-1:0]  wr,
  input  logic [PER_W-1:0] wdata,
  output logic [CTRL_W-1:0] rb_ctrl,
  output logic [PRE_W-1:0] rb_pre,
  output logic [PER_W-1:0] rb_per,
  output logic [PER_W-1:0] rb_duty,
  output logic [REGS-1:0]  busy,
  output logic             pwm_out
);
  logic [CTRL_W-1:0] sh_ctrl;
  logic [PRE_W-1:0]  sh_pre, act_pre, pre_cnt, pre_nx, act_pre_nx;
  logic [PER_W-1:0]  sh_per, sh_duty, act_per, act_duty, per_cnt;
  logic [PER_W-1:0]  per_nx, act_per_nx, act_duty_nx;
  logic run, oen, tick, bnd, load, out_nx;
  logic unused_ctl;

  pwmx_xfer #(.W(CTRL_W)) u_ctrl (.bclk, .brst_n, .pclk, .prst_n,
    .wr_en(wr[REG_CTRL]), .wdata(wdata[CTRL_W-1:0]), .hold(rb_ctrl),
    .busy(busy[REG_CTRL]), .pval(sh_ctrl));
  pwmx_xfer #(.W(PRE_W)) u_pre (.bclk, .brst_n, .pclk, .prst_n,
    .wr_en(wr[REG_PRE]), .wdata(wdata[PRE_W-1:0]), .hold(rb_pre),
    .busy(busy[REG_PRE]), .pval(sh_pre));
  pwmx_xfer #(.W(PER_W)) u_per (.bclk, .brst_n, .pclk, .prst_n,
    .wr_en(wr[REG_PER]), .wdata(wdata), .hold(rb_per),
    .busy(busy[REG_PER]), .pval(sh_per));
  pwmx_xfer #(.W(PER_W)) u_duty (.bclk, .brst_n, .pclk, .prst_n,
    .wr_en(wr[REG_DUTY]), .wdata(wdata), .hold(rb_duty),
    .busy(busy[REG_DUTY]), .pval(sh_duty));

  assign unused_ctl = ^sh_ctrl;
  assign run  = sh_ctrl[RUN_BIT];
  assign oen  = run && sh_ctrl[OEN_BIT];
  assign tick = (pre_cnt == act_pre);
  assign bnd  = tick && (per_cnt == act_per);

  // next-state logic
  always_comb begin
    if (!run) begin
      pre_nx = '0;
      per_nx = '0;
      load   = 1'b1;
    end else begin
      pre_nx = tick ? '0 : pre_cnt + 1'b1;
      per_nx = !tick ? per_cnt : (bnd ? '0 : per_cnt + 1'b1);
      load   = bnd;
    end
    act_pre_nx  = load ? sh_pre  : act_pre;
    act_per_nx  = load ? sh_per  : act_per;
    act_duty_nx = load ? sh_duty : act_duty;
    out_nx      = oen && (per_cnt < act_duty);
  end

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      pre_cnt  <= '0;
      per_cnt  <= '0;
      act_pre  <= '0;
      act_per  <= '0;
      act_duty <= '0;
      pwm_out  <= 1'b0;
    end else begin
      pre_cnt  <= pre_nx;
      per_cnt  <= per_nx;
      act_pre  <= act_pre_nx;
      act_per  <= act_per_nx;
      act_duty <= act_duty_nx;
      pwm_out  <= out_nx;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge pclk) disable iff (!prst_n)
    (per_cnt <= act_per) && (pre_cnt <= act_pre));

  // R8
  act_hold_chk: assert property (@(posedge pclk) disable iff (!prst_n)
    !$stable({act_pre, act_per, act_duty}) |-> $past(load));

  // R6
  full_hi_chk: assert property (@(posedge pclk) disable iff (!prst_n)
    (oen && (act_duty > act_per)) |=> pwm_out);
endmodule

// File: rtl/pwmx_top.sv
module pwmx_top
  import pwmx_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              bclk,
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int CH_W  = $clog2(SLOTS);
  localparam int RG_W  = $clog2(REGS);
  localparam int OFS_W = $clog2(SLOT_BYTES);

  logic [1:0] brs, prs;
  logic brst_n, prst_n;
  logic is_stat, aligned, stat_ok;
  logic [CH_W-1:0] slot, stat_idx;
  logic [RG_W-1:0] rsel;
  logic unused_hi;

  logic [CTRL_W-1:0] rb_ctrl [SLOTS];
  logic [PRE_W-1:0]  rb_pre  [SLOTS];
  logic [PER_W-1:0]  rb_per  [SLOTS];
  logic [PER_W-1:0]  rb_duty [SLOTS];
  logic [REGS-1:0]   busy_s  [SLOTS];

  // reset: asserted asynchronously, released on each domain's clock
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) brs <= 2'b00;
    else        brs <= {brs[0], 1'b1};
  end
  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) prs <= 2'b00;
    else        prs <= {prs[0], 1'b1};
  end
  assign brst_n = brs[1];
  assign prst_n = prs[1];

  assign unused_hi = ^bus_wdata[DATA_W-1:PER_W];
  assign is_stat   = bus_addr[ADDR_W-1];
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign slot      = bus_addr[OFS_W +: CH_W];
  assign rsel      = bus_addr[2 +: RG_W];
  assign stat_idx  = bus_addr[CH_W-1:0];
  assign stat_ok   = (bus_addr[ADDR_W-2:CH_W] == '0);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < NCH) begin : g_on
      logic [REGS-1:0] wr_s;
      for (genvar r = 0; r < REGS; r++) begin : g_we
        assign wr_s[r] = bus_we && !is_stat && aligned &&
                         (slot == CH_W'(s)) && (rsel == RG_W'(r));
      end
      pwmx_chan u_ch (
        .bclk, .brst_n, .pclk, .prst_n,
        .wr(wr_s), .wdata(bus_wdata[PER_W-1:0]),
        .rb_ctrl(rb_ctrl[s]), .rb_pre(rb_pre[s]), .rb_per(rb_per[s]),
        .rb_duty(rb_duty[s]), .busy(busy_s[s]), .pwm_out(pwm_out[s]));
    end else begin : g_off
      assign rb_ctrl[s] = '0;
      assign rb_pre[s]  = '0;
      assign rb_per[s]  = '0;
      assign rb_duty[s] = '0;
      assign busy_s[s]  = '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (is_stat) begin
      if (stat_ok) bus_rdata[REGS-1:0] = busy_s[stat_idx];
    end else if (aligned) begin
      unique case (reg_e'(rsel))
        REG_CTRL: bus_rdata[CTRL_W-1:0] = rb_ctrl[slot];
        REG_PRE:  bus_rdata[PRE_W-1:0]  = rb_pre[slot];
        REG_PER:  bus_rdata[PER_W-1:0]  = rb_per[slot];
        REG_DUTY: bus_rdata[PER_W-1:0]  = rb_duty[slot];
      endcase
    end
  end

  // R9
  unimpl_rd_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (!is_stat && (int'(slot) >= NCH)) |-> (bus_rdata == '0));

  // R2
  stat_hi_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    is_stat |-> (bus_rdata[DATA_W-1:REGS] == '0));
endmodule

// File: tb/tb_pwmx_top.sv
module tb_pwmx_top;
  import pwmx_pkg::*;

  logic bclk = 1'b0, pclk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [1:0] pout;
  int n_chk = 0, n_bad = 0;

  // {prescale, period, duty, control, high clocks per period, period clocks}
  localparam int NV = 7;
  localparam int VEC [NV][6] = '{
    '{1, 4, 2, 5,  4, 10},
    '{0, 9, 3, 5,  3, 10},
    '{2, 3, 4, 5, 12, 12},
    '{0, 7, 0, 5,  0,  8},
    '{3, 4, 5, 1,  0, 20},
    '{0, 5, 5, 0,  0,  6},
    '{0, 5, 5, 5,  5,  6}
  };

  pwmx_top dut (.bclk(bclk), .pclk(pclk), .rst_n(rst_n), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pout));

  always #4 bclk = ~bclk;
  always #6 pclk = ~pclk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge bclk);
    we = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
    @(negedge bclk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge bclk);
    addr = ADDR_W'(a);
    #1 d = int'(rdata);
  endtask

  task automatic wait_idle(input int ch);
    int s = 0;
    for (int i = 0; i < 200; i++) begin
      rd(64 + ch, s);
      if (s == 0) return;
    end
    check("R2 busy never cleared", s, 0);
  endtask

  task automatic prog(input int ch, input int pre, input int per, input int duty, input int ctl);
    wr(ch*16 + 4, pre);
    wr(ch*16 + 8, per);
    wr(ch*16 + 12, duty);
    wr(ch*16, ctl);
    wait_idle(ch);
  endtask

  task automatic measure(input int ch, input int p, output int hi, output int rises);
    logic prev, cur;
    hi = 0; rises = 0;
    @(negedge pclk) prev = pout[ch];
    for (int i = 0; i < 3*p; i++) begin
      @(negedge pclk) cur = pout[ch];
      if (cur) hi++;
      if (cur && !prev) rises++;
      prev = cur;
    end
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    @(negedge pclk) prev = pout[ch];
    for (int i = 0; i < 1000; i++) begin
      @(negedge pclk);
      if (pout[ch] && !prev) return;
      prev = pout[ch];
    end
    check("R8 no rising edge", 0, 1);
  endtask

  task automatic high_run(input int ch, output int n);
    n = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge pclk);
      if (!pout[ch]) return;
      n++;
    end
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, hi, rises, h1, h2;
    repeat (4) @(negedge bclk);
    rst_n = 1'b1;
    repeat (4) @(negedge bclk);

    // R10 reset state
    for (int a = 0; a < 16; a += 4) begin
      rd(a, v); check("R10 reg after reset", v, 0);
    end
    rd(64, v); check("R10 status after reset", v, 0);
    rd(65, v); check("R10 status after reset", v, 0);
    check("R10 outputs low", int'(pout), 0);

    // R2 / R3 busy flag and discarded write
    wr(4, 7);
    rd(64, v); check("R2 prescale busy bit", v, 2);
    wr(4, 9);
    wait_idle(0);
    rd(4, v); check("R3 write while busy dropped", v, 7);
    rd(64, v); check("R2 status clears", v, 0);

    // R1 field widths and read back
    wr(4, 32'hFFFF_FFFF); wr(8, 32'hFFFF_FFFF); wr(0, 32'hFF);
    wait_idle(0);
    rd(4, v); check("R1 prescale 10 bits", v, 1023);
    rd(8, v); check("R1 period 12 bits", v, 4095);
    rd(0, v); check("R1 control 3 bits", v, 7);
    wr(0, 0); wait_idle(0);

    // R9 unbuilt slots
    wr(36, 85); wr(48, 5);
    rd(36, v); check("R9 slot2 reads zero", v, 0);
    rd(48, v); check("R9 slot3 reads zero", v, 0);
    rd(66, v); check("R9 slot2 status zero", v, 0);
    rd(4, v); check("R9 slot0 untouched", v, 1023);
    rd(16, v); check("R9 slot1 untouched", v, 0);

    // R4 R5 R6 R7 vector table
    for (int i = 0; i < NV; i++) begin
      prog(0, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      repeat (250) @(negedge pclk);
      measure(0, VEC[i][5], hi, rises);
      check($sformatf("R5 R6 R7 high count vec%0d", i), hi, 3*VEC[i][4]);
      check($sformatf("R4 rising edges vec%0d", i), rises,
            (VEC[i][4] > 0 && VEC[i][4] < VEC[i][5]) ? 3 : 0);
    end

    // R11 second channel independent of the first
    prog(1, 0, 3, 1, 5);
    repeat (100) @(negedge pclk);
    measure(1, 4, hi, rises);
    check("R11 ch1 high count", hi, 3);
    measure(0, 6, hi, rises);
    check("R11 ch0 unchanged", hi, 15);

    // R7 control word 4 keeps output low
    wr(16, 4); wait_idle(1);
    repeat (20) @(negedge pclk);
    measure(1, 4, hi, rises);
    check("R7 ctrl=4 low", hi, 0);

    // R8 duty change mid-pulse waits for the boundary
    prog(0, 0, 99, 50, 5);
    repeat (250) @(negedge pclk);
    wait_rise(0);
    fork
      high_run(0, h1);
      wr(12, 10);
    join
    wait_idle(0);
    check("R8 running pulse keeps length", h1, 50);
    wait_rise(0);
    high_run(0, h2);
    check("R8 next pulse uses new duty", h2, 10);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule